// File: doc/BRIEF.md
# PLL Divider Parameter Search Engine

This block turns a pair of frequencies into the settings a fractional-N PLL needs. A caller presents a reference frequency and a requested output frequency, both unsigned integers in Hz, and pulses a start strobe. The engine works out four settings: a pre-divider P, a feedback multiplier M, an output shift S and a 16-bit fractional word K. It reports them with a one-cycle done pulse and an error flag.

The engine first rejects unusable requests. It then picks one of two modes. Integer mode applies when both frequencies are whole multiples of 1 MHz; fractional mode covers every other request. It then walks the candidate space one candidate per clock and stops at the first hit. In fractional mode a restoring divider computes K after the hit. The same divider handles the megahertz splits at the start of a request.

Top module: `pll_param_search`

## Requirements
- R1: A request with reference 0, target 0, or target equal to the reference finishes with err_o=1 and P, M, S, K all reported as 0.
- R2: Targets below 37,000,000 Hz or above 4,500,000,000 Hz are rejected as in R1; both limits themselves are accepted.
- R3: For each S in 0..6 the VCO candidate is the output base shifted left by S. A candidate outside 2,250,000,000..4,500,000,000 Hz (inclusive) is never reported.
- R4: When the reference and the target are both exact multiples of 1,000,000 Hz, the search uses P in 2..4 and M in 64..1023, and K is reported as 0.
- R5: Otherwise the target is split into a whole-MHz part and a sub-MHz remainder. The VCO candidate is built from the whole-MHz part, and P ranges over 1..4 with M in 64..1023.
- R6: A candidate is a hit only when the VCO candidate equals floor(M * reference / P).
- R7: In fractional mode, K is the low 16 bits of floor(((remainder << S) * 65535) / floor(reference / P)).
- R8: Candidates are visited with S outermost (ascending), then P (ascending), then M innermost (ascending). The first hit is reported.
- R9: If no candidate hits, the engine finishes with err_o=1 and P, M, S, K all 0.
- R10: start_i is taken only while busy_o is low. busy_o is high from the cycle after an accepted start until the result is registered. done_o pulses for exactly one cycle, in which busy_o is low. The outputs change only in a done cycle and otherwise hold. A start_i raised while busy_o is high is ignored.
- R11: After reset, busy_o, done_o and err_o are 0 and P, M, S, K read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start a search (taken when idle) |
| ref_hz_i | input | FREQ_W (33) | Reference frequency in Hz |
| tgt_hz_i | input | FREQ_W (33) | Requested output frequency in Hz |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Last request produced no settings |
| pdiv_o | output | P_W (3) | Pre-divider P |
| mmul_o | output | M_W (10) | Feedback multiplier M |
| sshift_o | output | S_W (3) | Output shift S |
| kfrac_o | output | K_W (16) | Fractional word K |

## Verification
The bench builds the engine with its default parameters: 64-bit arithmetic, M from 64 to 1023 and S up to 6. These are the full limits, so a 24 MHz reference reaches both edges of the VCO window and both ends of the accepted target range. A 1 MHz reference drives the search through its complete integer space of 2880 candidates before it reports a miss. The fractional cases exercise K generation through both divider passes, and an ignored mid-search start shows that the latched request survives.

// File: rtl/pll_search_pkg.sv
package pll_search_pkg;
  localparam int CALC_W = 64;
  typedef logic [CALC_W-1:0] calc_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_DREF,
    ST_DTGT,
    ST_SCAN,
    ST_DFREF,
    ST_DK
  } srch_state_e;
endpackage

// File: rtl/pll_div_restoring.sv
module pll_div_restoring #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go_i,
  input  logic [W-1:0] num_i,
  input  logic [W-1:0] den_i,
  output logic         done_o,
  output logic [W-1:0] quo_o,
  output logic [W-1:0] rem_o
);
  localparam int CNT_W = $clog2(W);

  logic [W-1:0]     quo_q, quo_d;
  logic [W-1:0]     rem_q, rem_d;
  logic [W-1:0]     den_q, den_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             run_q, run_d;
  logic             done_q, done_d;
  logic [W:0]       trial;
  logic [W:0]       diff;

  always_comb begin
    trial = {rem_q, quo_q[W-1]};
    diff  = trial - {1'b0, den_q};
    quo_d  = quo_q;
    rem_d  = rem_q;
    den_d  = den_q;
    cnt_d  = cnt_q;
    run_d  = run_q;
    done_d = 1'b0;
    if (go_i && !run_q) begin
      quo_d = num_i;
      rem_d = '0;
      den_d = den_i;
      cnt_d = '0;
      run_d = 1'b1;
    end else if (run_q) begin
      if (trial >= {1'b0, den_q}) begin
        rem_d = diff[W-1:0];
        quo_d = {quo_q[W-2:0], 1'b1};
      end else begin
        rem_d = trial[W-1:0];
        quo_d = {quo_q[W-2:0], 1'b0};
      end
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == CNT_W'(W - 1)) begin
        run_d  = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quo_q  <= '0;
      rem_q  <= '0;
      den_q  <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      quo_q  <= quo_d;
      rem_q  <= rem_d;
      den_q  <= den_d;
      cnt_q  <= cnt_d;
      run_q  <= run_d;
      done_q <= done_d;
    end
  end

  assign done_o = done_q;
  assign quo_o  = quo_q;
  assign rem_o  = rem_q;
endmodule

// File: rtl/pll_cand_check.sv
module pll_cand_check
  import pll_search_pkg::*;
#(
  parameter int    P_W     = 3,
  parameter int    M_W     = 10,
  parameter int    S_W     = 3,
  parameter calc_t VCO_MIN = 64'd2_250_000_000,
  parameter calc_t VCO_MAX = 64'd4_500_000_000
) (
  input  calc_t          base_i,
  input  calc_t          ref_i,
  input  logic [S_W-1:0] s_i,
  input  logic [P_W-1:0] p_i,
  input  logic [M_W-1:0] m_i,
  output logic           in_win_o,
  output logic           hit_o
);
  calc_t fvco;
  calc_t prod;
  calc_t lo_bound;
  calc_t hi_bound;

  // floor(prod / p) == fvco  <=>  fvco*p <= prod < fvco*p + p
  always_comb begin
    fvco     = base_i << s_i;
    prod     = calc_t'(m_i) * ref_i;
    lo_bound = fvco * calc_t'(p_i);
    hi_bound = lo_bound + calc_t'(p_i);
    in_win_o = (fvco >= VCO_MIN) && (fvco <= VCO_MAX);
    hit_o    = in_win_o && (prod >= lo_bound) && (prod < hi_bound);
  end
endmodule

// File: rtl/pll_param_search.sv
module pll_param_search
  import pll_search_pkg::*;
#(
  parameter int    FREQ_W    = 33,
  parameter int    P_W       = 3,
  parameter int    M_W       = 10,
  parameter int    S_W       = 3,
  parameter int    K_W       = 16,
  parameter int    M_LO      = 64,
  parameter int    M_HI      = 1023,
  parameter int    P_INT_LO  = 2,
  parameter int    P_FRAC_LO = 1,
  parameter int    P_HI      = 4,
  parameter int    S_HI      = 6,
  parameter calc_t OUT_MIN   = 64'd37_000_000,
  parameter calc_t OUT_MAX   = 64'd4_500_000_000,
  parameter calc_t VCO_MIN   = 64'd2_250_000_000,
  parameter calc_t VCO_MAX   = 64'd4_500_000_000,
  parameter calc_t MHZ       = 64'd1_000_000,
  parameter calc_t K_SCALE   = 64'd65535
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [FREQ_W-1:0] ref_hz_i,
  input  logic [FREQ_W-1:0] tgt_hz_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [P_W-1:0]    pdiv_o,
  output logic [M_W-1:0]    mmul_o,
  output logic [S_W-1:0]    sshift_o,
  output logic [K_W-1:0]    kfrac_o
);
  localparam logic [M_W-1:0] M_FIRST = M_W'(M_LO);
  localparam logic [M_W-1:0] M_LAST  = M_W'(M_HI);
  localparam logic [P_W-1:0] P_LAST  = P_W'(P_HI);
  localparam logic [S_W-1:0] S_LAST  = S_W'(S_HI);

  // reset: asynchronous assert, synchronous release
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  srch_state_e state_q, state_d;
  calc_t ref_q, ref_d;
  calc_t tgt_q, tgt_d;
  calc_t base_q, base_d;
  calc_t frac_q, frac_d;
  logic  int_q, int_d;
  logic  refint_q, refint_d;
  logic [S_W-1:0] s_q, s_d;
  logic [P_W-1:0] p_q, p_d;
  logic [M_W-1:0] m_q, m_d;
  logic           done_q, done_d;
  logic           err_q, err_d;
  logic [P_W-1:0] pdiv_q, pdiv_d;
  logic [M_W-1:0] mmul_q, mmul_d;
  logic [S_W-1:0] sshift_q, sshift_d;
  logic [K_W-1:0] kfrac_q, kfrac_d;

  logic  div_go;
  calc_t div_num, div_den;
  logic  div_done;
  calc_t div_quo, div_rem;
  logic  in_win, hit;
  logic [P_W-1:0] p_first;

  pll_div_restoring #(.W(CALC_W)) u_div (
    .clk    (clk),
    .rst_n  (rst_sync_q),
    .go_i   (div_go),
    .num_i  (div_num),
    .den_i  (div_den),
    .done_o (div_done),
    .quo_o  (div_quo),
    .rem_o  (div_rem)
  );

  pll_cand_check #(
    .P_W(P_W), .M_W(M_W), .S_W(S_W), .VCO_MIN(VCO_MIN), .VCO_MAX(VCO_MAX)
  ) u_cand (
    .base_i   (base_q),
    .ref_i    (ref_q),
    .s_i      (s_q),
    .p_i      (p_q),
    .m_i      (m_q),
    .in_win_o (in_win),
    .hit_o    (hit)
  );

  assign p_first = int_q ? P_W'(P_INT_LO) : P_W'(P_FRAC_LO);

  always_comb begin
    state_d  = state_q;
    ref_d    = ref_q;
    tgt_d    = tgt_q;
    base_d   = base_q;
    frac_d   = frac_q;
    int_d    = int_q;
    refint_d = refint_q;
    s_d      = s_q;
    p_d      = p_q;
    m_d      = m_q;
    done_d   = 1'b0;
    err_d    = err_q;
    pdiv_d   = pdiv_q;
    mmul_d   = mmul_q;
    sshift_d = sshift_q;
    kfrac_d  = kfrac_q;
    div_go   = 1'b0;
    div_num  = '0;
    div_den  = MHZ;

    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          ref_d   = calc_t'(ref_hz_i);
          tgt_d   = calc_t'(tgt_hz_i);
          state_d = ST_CHECK;
        end
      end
      ST_CHECK: begin
        if ((ref_q == '0) || (tgt_q == '0) || (tgt_q == ref_q) ||
            (tgt_q < OUT_MIN) || (tgt_q > OUT_MAX)) begin
          done_d   = 1'b1;
          err_d    = 1'b1;
          pdiv_d   = '0;
          mmul_d   = '0;
          sshift_d = '0;
          kfrac_d  = '0;
          state_d  = ST_IDLE;
        end else begin
          div_go  = 1'b1;
          div_num = ref_q;
          state_d = ST_DREF;
        end
      end
      ST_DREF: begin
        if (div_done) begin
          refint_d = (div_rem == '0);
          div_go   = 1'b1;
          div_num  = tgt_q;
          state_d  = ST_DTGT;
        end
      end
      ST_DTGT: begin
        if (div_done) begin
          int_d   = refint_q && (div_rem == '0);
          frac_d  = div_rem;
          base_d  = (refint_q && (div_rem == '0)) ? tgt_q : div_quo * MHZ;
          s_d     = '0;
          p_d     = (refint_q && (div_rem == '0)) ? P_W'(P_INT_LO) : P_W'(P_FRAC_LO);
          m_d     = M_FIRST;
          state_d = ST_SCAN;
        end
      end
      ST_SCAN: begin
        if (hit) begin
          if (int_q) begin
            done_d   = 1'b1;
            err_d    = 1'b0;
            pdiv_d   = p_q;
            mmul_d   = m_q;
            sshift_d = s_q;
            kfrac_d  = '0;
            state_d  = ST_IDLE;
          end else begin
            div_go  = 1'b1;
            div_num = ref_q;
            div_den = calc_t'(p_q);
            state_d = ST_DFREF;
          end
        end else if (!in_win || ((m_q == M_LAST) && (p_q == P_LAST))) begin
          if (s_q == S_LAST) begin
            done_d   = 1'b1;
            err_d    = 1'b1;
            pdiv_d   = '0;
            mmul_d   = '0;
            sshift_d = '0;
            kfrac_d  = '0;
            state_d  = ST_IDLE;
          end else begin
            s_d = s_q + 1'b1;
            p_d = p_first;
            m_d = M_FIRST;
          end
        end else if (m_q == M_LAST) begin
          p_d = p_q + 1'b1;
          m_d = M_FIRST;
        end else begin
          m_d = m_q + 1'b1;
        end
      end
      ST_DFREF: begin
        if (div_done) begin
          div_go  = 1'b1;
          div_num = (frac_q << s_q) * K_SCALE;
          div_den = div_quo;
          state_d = ST_DK;
        end
      end
      ST_DK: begin
        if (div_done) begin
          done_d   = 1'b1;
          err_d    = 1'b0;
          pdiv_d   = p_q;
          mmul_d   = m_q;
          sshift_d = s_q;
          kfrac_d  = div_quo[K_W-1:0];
          state_d  = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      state_q  <= ST_IDLE;
      ref_q    <= '0;
      tgt_q    <= '0;
      base_q   <= '0;
      frac_q   <= '0;
      int_q    <= 1'b0;
      refint_q <= 1'b0;
      s_q      <= '0;
      p_q      <= '0;
      m_q      <= '0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      pdiv_q   <= '0;
      mmul_q   <= '0;
      sshift_q <= '0;
      kfrac_q  <= '0;
    end else begin
      state_q  <= state_d;
      ref_q    <= ref_d;
      tgt_q    <= tgt_d;
      base_q   <= base_d;
      frac_q   <= frac_d;
      int_q    <= int_d;
      refint_q <= refint_d;
      s_q      <= s_d;
      p_q      <= p_d;
      m_q      <= m_d;
      done_q   <= done_d;
      err_q    <= err_d;
      pdiv_q   <= pdiv_d;
      mmul_q   <= mmul_d;
      sshift_q <= sshift_d;
      kfrac_q  <= kfrac_d;
    end
  end

  assign busy_o   = (state_q != ST_IDLE);
  assign done_o   = done_q;
  assign err_o    = err_q;
  assign pdiv_o   = pdiv_q;
  assign mmul_o   = mmul_q;
  assign sshift_o = sshift_q;
  assign kfrac_o  = kfrac_q;
endmodule

// File: rtl/pll_param_search_chk.sv
module pll_param_search_chk #(
  parameter int P_W  = 3,
  parameter int M_W  = 10,
  parameter int S_W  = 3,
  parameter int K_W  = 16,
  parameter int M_LO = 64,
  parameter int M_HI = 1023,
  parameter int P_HI = 4,
  parameter int S_HI = 6
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start_i,
  input logic           busy_o,
  input logic           done_o,
  input logic           err_o,
  input logic [P_W-1:0] pdiv_o,
  input logic [M_W-1:0] mmul_o,
  input logic [S_W-1:0] sshift_o,
  input logic [K_W-1:0] kfrac_o
);
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_done_not_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  p_start_taken_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable({err_o, pdiv_o, mmul_o, sshift_o, kfrac_o}));

  p_err_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && err_o) |-> (pdiv_o == '0 && mmul_o == '0 && sshift_o == '0 && kfrac_o == '0));

  p_ranges_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !err_o) |-> (int'(mmul_o) >= M_LO && int'(mmul_o) <= M_HI &&
                            pdiv_o != '0 && int'(pdiv_o) <= P_HI && int'(sshift_o) <= S_HI));
endmodule

bind pll_param_search pll_param_search_chk #(
  .P_W(P_W), .M_W(M_W), .S_W(S_W), .K_W(K_W),
  .M_LO(M_LO), .M_HI(M_HI), .P_HI(P_HI), .S_HI(S_HI)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start_i  (start_i),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .err_o    (err_o),
  .pdiv_o   (pdiv_o),
  .mmul_o   (mmul_o),
  .sshift_o (sshift_o),
  .kfrac_o  (kfrac_o)
);

// File: tb/sim_pll_param_search.sv
module sim_pll_param_search;
  localparam int CLK_NS = 10;
  localparam int WATCHDOG = 190000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [32:0] ref_hz_i = '0;
  logic [32:0] tgt_hz_i = '0;
  logic        busy_o, done_o, err_o;
  logic [2:0]  pdiv_o;
  logic [9:0]  mmul_o;
  logic [2:0]  sshift_o;
  logic [15:0] kfrac_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  pll_param_search u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .ref_hz_i(ref_hz_i), .tgt_hz_i(tgt_hz_i),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
    .pdiv_o(pdiv_o), .mmul_o(mmul_o), .sshift_o(sshift_o), .kfrac_o(kfrac_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // behavioural model of the requirements
  function automatic void model(input longint unsigned fin, input longint unsigned fo,
                                output bit e, output int ep, output int em,
                                output int es, output int ek);
    longint unsigned base, frac, fvco, fref;
    int plo;
    e = 1; ep = 0; em = 0; es = 0; ek = 0;
    if (fin == 0 || fo == 0 || fo == fin) return;
    if (fo < 64'd37_000_000 || fo > 64'd4_500_000_000) return;
    if (fin % 1000000 == 0 && fo % 1000000 == 0) begin
      base = fo; frac = 0; plo = 2;
    end else begin
      base = (fo / 1000000) * 1000000; frac = fo % 1000000; plo = 1;
    end
    for (int s = 0; s <= 6; s++) begin
      fvco = base << s;
      if (fvco < 64'd2_250_000_000 || fvco > 64'd4_500_000_000) continue;
      for (int p = plo; p <= 4; p++) begin
        for (int m = 64; m <= 1023; m++) begin
          if (fvco == (longint'(m) * fin) / longint'(p)) begin
            e = 0; ep = p; em = m; es = s;
            if (plo == 1) begin
              fref = fin / longint'(p);
              ek = int'(((frac << s) * 65535 / fref) & 64'hffff);
            end
            return;
          end
        end
      end
    end
  endfunction

  task automatic run(input longint unsigned fin, input longint unsigned fo,
                     input string req, input bit poke_mid);
    bit e; int ep, em, es, ek;
    bit busy_bad;
    int wait_cyc;
    logic [2:0] hp; logic [9:0] hm; logic [2:0] hs; logic [15:0] hk; logic he;
    model(fin, fo, e, ep, em, es, ek);
    @(negedge clk);
    start_i = 1'b1; ref_hz_i = fin[32:0]; tgt_hz_i = fo[32:0];
    @(negedge clk);
    start_i = 1'b0;
    busy_bad = 1'b0;
    wait_cyc = 0;
    // compared every clock: busy held until the single done cycle
    while (!done_o && wait_cyc < 60000) begin
      if (!busy_o) busy_bad = 1'b1;
      if (poke_mid && wait_cyc == 3) begin
        start_i = 1'b1; ref_hz_i = 33'd13_000_000; tgt_hz_i = 33'd777_777_777;
      end else begin
        start_i = 1'b0;
      end
      @(negedge clk);
      wait_cyc++;
    end
    start_i = 1'b0;
    chk(done_o == 1'b1, "R10", {req, " done reached"}, done_o, 1);
    chk(!busy_bad && !busy_o, "R10", {req, " busy until done"}, busy_o, 0);
    chk(err_o == e, req, "err", err_o, e);
    chk(pdiv_o == ep[2:0] && mmul_o == em[9:0], req, "P*1024+M",
        longint'(pdiv_o) * 1024 + mmul_o, longint'(ep) * 1024 + em);
    chk(sshift_o == es[2:0] && kfrac_o == ek[15:0], req, "S*65536+K",
        longint'(sshift_o) * 65536 + kfrac_o, longint'(es) * 65536 + ek);
    hp = pdiv_o; hm = mmul_o; hs = sshift_o; hk = kfrac_o; he = err_o;
    @(negedge clk);
    chk(!done_o && !busy_o, "R10", {req, " done one cycle"}, done_o, 0);
    chk(hp == pdiv_o && hm == mmul_o && hs == sshift_o && hk == kfrac_o && he == err_o,
        "R10", {req, " outputs held"}, kfrac_o, hk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, WATCHDOG);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R11 reset state
    chk(!busy_o && !done_o && !err_o, "R11", "flags after reset", {busy_o, done_o, err_o}, 0);
    chk(pdiv_o == 0 && mmul_o == 0 && sshift_o == 0 && kfrac_o == 0, "R11",
        "fields after reset", mmul_o, 0);
    // R1 invalid requests
    run(64'd0, 64'd1_000_000_000, "R1", 0);
    run(64'd24_000_000, 64'd0, "R1", 0);
    run(64'd100_000_000, 64'd100_000_000, "R1", 0);
    // R2 range edges
    run(64'd24_000_000, 64'd36_999_999, "R2", 0);
    run(64'd24_000_000, 64'd4_500_000_001, "R2", 0);
    run(64'd24_000_000, 64'd37_000_000, "R2", 0);
    // R3 window edges (S=0 at 2250 MHz and at 4500 MHz)
    run(64'd24_000_000, 64'd2_250_000_000, "R3", 0);
    run(64'd24_000_000, 64'd4_500_000_000, "R3", 0);
    // R4 integer mode, R6 truncated match, R8 order
    run(64'd24_000_000, 64'd1_000_000_000, "R4", 0);
    run(64'd24_000_000, 64'd1_200_000_000, "R8", 0);
    run(64'd27_000_000, 64'd594_000_000, "R6", 0);
    // R5 / R7 fractional mode
    run(64'd24_000_000, 64'd1_000_500_000, "R7", 0);
    run(64'd24_576_000, 64'd1_000_000_000, "R5", 0);
    run(64'd25_000_000, 64'd333_333_333, "R7", 0);
    // R9 exhausted search
    run(64'd1_000_000, 64'd100_000_000, "R9", 0);
    // R10 start during busy ignored
    run(64'd24_000_000, 64'd1_000_000_000, "R10", 1);
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule